// File: doc/BRIEF.md
# TDM Pipeline Phase Scheduler

This block tells every stage of a time-multiplexed router pipeline which virtual-channel domain it serves in the current cycle. A free-running domain counter marks the domain of the first stage, route computation. Each later stage serves the domain that the first stage served a fixed number of cycles earlier. So a flit whose domain is active in one stage finds the same domain active in the next stage one cycle later. All inputs of the router use the same select, and every stage of a cycle serves a different domain.

The starting domain is sampled from an input while reset is held. Routers joined by a link can therefore be staggered by the pipeline depth plus one. Stages can be merged by a parameter. A merged stage shares the phase register, the domain number and the select of the stage in front of it, so the pipeline handles one fewer domain in parallel. Each stage drives a binary domain number and a one-hot domain enable. Both are registers that change on the same edge as the counter.

Top module: `tdm_phase_sched`

## Requirements
- R1: While `rst` is high, each clock edge loads the first-stage domain (stage 0, bits [DW-1:0] of `stage_dom_o`) from `start_dom_i`. It stays at that value for as long as reset is held. A change of `start_dom_i` while `rst` is low has no effect on any output.
- R2: After reset is released, the first-stage domain goes up by one on every clock edge and wraps from NUM_DOM-1 to 0.
- R3: The phase of stage k is the number of stages j, with 1 ≤ j ≤ k, whose merge bit is clear. Stage k serves (first-stage domain − phase of k) mod NUM_DOM. Its domain number sits at bits [k*DW +: DW] of `stage_dom_o`.
- R4: A stage with its bit set in `MERGE_MASK` (bit 0 is ignored) has no phase of its own. It always shows the same domain and enable as the stage before it.
- R5: Two stages with different phases never serve the same domain in the same cycle, provided NUM_DOM is at least the number of phases.
- R6: The enable of stage k (bits [k*NUM_DOM +: NUM_DOM] of `stage_en_o`) is one-hot. The bit set is the one at the stage's domain number.
- R7: A start value of NUM_DOM or more is reduced modulo NUM_DOM before it is loaded.
- R8: A stage that opens a new phase serves, in each cycle after the first cycle out of reset, the domain that the stage before it served in the previous cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; loads the starting domain |
| start_dom_i | input | DW = clog2(NUM_DOM) | First-stage domain to load during reset |
| stage_dom_o | output | NUM_STG*DW | Binary domain number of each stage, stage 0 in the low bits |
| stage_en_o | output | NUM_STG*NUM_DOM | One-hot domain enable of each stage, stage 0 in the low bits |

## Verification
The bench drives two configurations. The first has ten domains and four separate stages. The second has six domains with route and VC allocation merged, and switch allocation and traversal merged. For each configuration it sweeps every value of the start input, including the out-of-range values that must fold back, so a wrong seed, a wrong fold or an off-by-one in the stagger shows up at a particular offset. Each run lasts longer than two full wraps of the counter. It covers the turn from the last domain back to zero in every stage, and it compares each stage with its neighbour one cycle later. The start input is changed in the middle of each run and the run goes on. This shows that the seed is taken only under reset. The merged configuration is the one that separates stages that share a phase from stages that start a new one.

// File: rtl/tdm_phase_pkg.sv
package tdm_phase_pkg;

    localparam int MAX_STAGES  = 4;
    localparam int MAX_DOMAINS = 10;
    localparam int MASK_W      = 8;

    // Reduce a non-negative value into the domain range.
    function automatic int fold_dom(input int value, input int n_dom);
        return value % n_dom;
    endfunction

    // Advance one domain with wrap.
    function automatic int next_dom(input int value, input int n_dom);
        return (value + 1 >= n_dom) ? 0 : value + 1;
    endfunction

    // Domain that was current `back` cycles earlier.
    function automatic int lag_dom(input int value, input int back, input int n_dom);
        return ((value - back) % n_dom + n_dom) % n_dom;
    endfunction

    // Phase slot of stage k given a merge mask (bit j: stage j joins j-1).
    function automatic int phase_slot(input logic [MASK_W-1:0] mask, input int k);
        int slot;
        slot = 0;
        for (int j = 1; j < MASK_W; j++) begin
            if (j <= k && !mask[j]) slot++;
        end
        return slot;
    endfunction

    // Whether stage k opens a new phase slot.
    function automatic bit opens_phase(input logic [MASK_W-1:0] mask, input int k);
        return (k == 0) || !mask[k];
    endfunction

endpackage

// File: rtl/tdm_dom_counter.sv
module tdm_dom_counter
    import tdm_phase_pkg::*;
#(
    parameter int NUM_DOM = 10,
    parameter int DW      = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [DW-1:0] seed_i,
    output logic [DW-1:0] cnt_q,
    output logic [DW-1:0] cnt_d
);

    always_comb begin
        if (rst) cnt_d = DW'(fold_dom(int'(seed_i), NUM_DOM));
        else     cnt_d = DW'(next_dom(int'(cnt_q), NUM_DOM));
    end

    always_ff @(posedge clk) begin
        cnt_q <= cnt_d;
    end

    // R2: one step per cycle with wrap once out of reset
    a_r2_advance: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> (int'(cnt_q) == next_dom(int'($past(cnt_q)), NUM_DOM)));

    // R7: counter never leaves the domain range
    a_r7_in_range: assert property (@(posedge clk) disable iff (rst)
        int'(cnt_q) < NUM_DOM);

endmodule

// File: rtl/tdm_stage_map.sv
module tdm_stage_map
    import tdm_phase_pkg::*;
#(
    parameter int                 NUM_DOM    = 10,
    parameter int                 NUM_STG    = 4,
    parameter int                 DW         = 4,
    parameter logic [NUM_STG-1:0] MERGE_MASK = '0
) (
    input  logic [DW-1:0]         first_d,
    output logic [NUM_STG*DW-1:0] stage_d
);

    for (genvar k = 0; k < NUM_STG; k++) begin : g_map
        localparam int SLOT = phase_slot(MASK_W'(MERGE_MASK), k);
        assign stage_d[k*DW +: DW] = DW'(lag_dom(int'(first_d), SLOT, NUM_DOM));
    end

endmodule

// File: rtl/tdm_stage_bank.sv
module tdm_stage_bank
    import tdm_phase_pkg::*;
#(
    parameter int                 NUM_DOM    = 10,
    parameter int                 NUM_STG    = 4,
    parameter int                 DW         = 4,
    parameter logic [NUM_STG-1:0] MERGE_MASK = '0
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic [NUM_STG*DW-1:0]      stage_d,
    output logic [NUM_STG*DW-1:0]      dom_o,
    output logic [NUM_STG*NUM_DOM-1:0] en_o
);

    for (genvar k = 0; k < NUM_STG; k++) begin : g_stg
        logic [DW-1:0]      r_dom;
        logic [NUM_DOM-1:0] r_en;

        if (opens_phase(MASK_W'(MERGE_MASK), k)) begin : g_own
            logic [NUM_DOM-1:0] n_en;

            always_comb begin
                for (int d = 0; d < NUM_DOM; d++) begin
                    n_en[d] = (stage_d[k*DW +: DW] == DW'(d));
                end
            end

            always_ff @(posedge clk) begin
                r_dom <= stage_d[k*DW +: DW];
                r_en  <= n_en;
            end

            // R6: enable is one-hot on the stage's domain
            a_r6_onehot: assert property (@(posedge clk) disable iff (rst)
                $onehot(r_en) && r_en[r_dom]);

            if (k > 0) begin : g_hand
                // R8: new phase takes over the previous stage's domain one cycle later
                a_r8_handoff: assert property (@(posedge clk) disable iff (rst)
                    !$past(rst) |-> (r_dom == $past(g_stg[k-1].r_dom)));
            end
        end else begin : g_shared
            assign r_dom = g_stg[k-1].r_dom;
            assign r_en  = g_stg[k-1].r_en;
        end

        assign dom_o[k*DW +: DW]          = r_dom;
        assign en_o[k*NUM_DOM +: NUM_DOM] = r_en;
    end

endmodule

// File: rtl/tdm_phase_sched.sv
module tdm_phase_sched
    import tdm_phase_pkg::*;
#(
    parameter int                 NUM_DOM    = 10,
    parameter int                 NUM_STG    = 4,
    parameter logic [NUM_STG-1:0] MERGE_MASK = '0,
    localparam int                DW         = (NUM_DOM > 1) ? $clog2(NUM_DOM) : 1
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic [DW-1:0]              start_dom_i,
    output logic [NUM_STG*DW-1:0]      stage_dom_o,
    output logic [NUM_STG*NUM_DOM-1:0] stage_en_o
);

    logic [DW-1:0]         first_q;
    logic [DW-1:0]         first_d;
    logic [NUM_STG*DW-1:0] stage_d;

    tdm_dom_counter #(
        .NUM_DOM (NUM_DOM),
        .DW      (DW)
    ) u_counter (
        .clk    (clk),
        .rst    (rst),
        .seed_i (start_dom_i),
        .cnt_q  (first_q),
        .cnt_d  (first_d)
    );

    tdm_stage_map #(
        .NUM_DOM    (NUM_DOM),
        .NUM_STG    (NUM_STG),
        .DW         (DW),
        .MERGE_MASK (MERGE_MASK)
    ) u_map (
        .first_d (first_d),
        .stage_d (stage_d)
    );

    tdm_stage_bank #(
        .NUM_DOM    (NUM_DOM),
        .NUM_STG    (NUM_STG),
        .DW         (DW),
        .MERGE_MASK (MERGE_MASK)
    ) u_bank (
        .clk     (clk),
        .rst     (rst),
        .stage_d (stage_d),
        .dom_o   (stage_dom_o),
        .en_o    (stage_en_o)
    );

    // R1: stage 0 register follows the counter register
    a_r1_first_stage: assert property (@(posedge clk) disable iff (rst)
        stage_dom_o[DW-1:0] == first_q);

    // R5: stages in different phase slots never share a domain
    for (genvar i = 0; i < NUM_STG; i++) begin : g_pi
        for (genvar j = i + 1; j < NUM_STG; j++) begin : g_pj
            if (phase_slot(MASK_W'(MERGE_MASK), i) != phase_slot(MASK_W'(MERGE_MASK), j)) begin : g_chk
                a_r5_distinct: assert property (@(posedge clk) disable iff (rst)
                    stage_dom_o[i*DW +: DW] != stage_dom_o[j*DW +: DW]);
            end
        end
    end

endmodule

// File: tb/tdm_phase_sched_bench.sv
`timescale 1ns/1ps
module tdm_phase_sched_bench;

    localparam int A_D = 10;
    localparam int A_W = 4;
    localparam int A_M = 0;        // four separate stages
    localparam int B_D = 6;
    localparam int B_W = 3;
    localparam int B_M = 'b1010;   // stage 1 joins 0, stage 3 joins 2
    localparam int NS  = 4;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic             rst_a = 1'b1;
    logic             rst_b = 1'b1;
    logic [A_W-1:0]   off_a = '0;
    logic [B_W-1:0]   off_b = '0;
    logic [NS*A_W-1:0] dom_a;
    logic [NS*A_D-1:0] en_a;
    logic [NS*B_W-1:0] dom_b;
    logic [NS*B_D-1:0] en_b;

    int checks = 0;
    int fails  = 0;

    tdm_phase_sched #(.NUM_DOM(A_D), .NUM_STG(NS), .MERGE_MASK(4'(A_M))) u_tdm_phase_sched (
        .clk(clk), .rst(rst_a), .start_dom_i(off_a), .stage_dom_o(dom_a), .stage_en_o(en_a));

    tdm_phase_sched #(.NUM_DOM(B_D), .NUM_STG(NS), .MERGE_MASK(4'(B_M))) u_tdm_phase_sched_m (
        .clk(clk), .rst(rst_b), .start_dom_i(off_b), .stage_dom_o(dom_b), .stage_en_o(en_b));

    function automatic int dom_of(input int sel, input int k);
        return (sel == 0) ? int'(dom_a[k*A_W +: A_W]) : int'(dom_b[k*B_W +: B_W]);
    endfunction

    function automatic int en_of(input int sel, input int k);
        return (sel == 0) ? int'(en_a[k*A_D +: A_D]) : int'(en_b[k*B_D +: B_D]);
    endfunction

    function automatic int slot(input int mask, input int k);
        int s;
        s = 0;
        for (int j = 1; j <= k; j++) if (((mask >> j) & 1) == 0) s++;
        return s;
    endfunction

    task automatic check_int(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic check_stages(input int sel, input int nd, input int mask, input int first);
        for (int k = 0; k < NS; k++) begin
            int exp;
            exp = ((first - slot(mask, k)) % nd + nd) % nd;
            if (k > 0 && ((mask >> k) & 1) == 1)
                check_int("R4", $sformatf("cfg%0d merged stage %0d dom", sel, k), dom_of(sel, k), exp);
            else
                check_int("R3", $sformatf("cfg%0d stage %0d dom", sel, k), dom_of(sel, k), exp);
            check_int("R6", $sformatf("cfg%0d stage %0d enable", sel, k), en_of(sel, k), 1 << exp);
        end
        for (int i = 0; i < NS; i++)
            for (int j = i + 1; j < NS; j++)
                if (slot(mask, i) != slot(mask, j))
                    check_int("R5", $sformatf("cfg%0d stages %0d/%0d differ", sel, i, j),
                              int'(dom_of(sel, i) != dom_of(sel, j)), 1);
    endtask

    task automatic drive(input int sel, input bit r, input int off);
        if (sel == 0) begin rst_a = r; off_a = A_W'(off); end
        else          begin rst_b = r; off_b = B_W'(off); end
    endtask

    task automatic run_seq(input int sel, input int nd, input int mask, input int off, input int wid);
        int base;
        int prev [NS];
        base = off % nd;
        @(negedge clk);
        drive(sel, 1'b1, off);
        @(negedge clk);
        check_int((off >= nd) ? "R7" : "R1", $sformatf("cfg%0d seed %0d load", sel, off),
                  dom_of(sel, 0), base);
        check_stages(sel, nd, mask, base);
        @(negedge clk);
        check_int("R1", $sformatf("cfg%0d seed %0d hold in reset", sel, off), dom_of(sel, 0), base);
        for (int k = 0; k < NS; k++) prev[k] = dom_of(sel, k);
        drive(sel, 1'b0, off);
        for (int n = 1; n <= 2 * nd + 3; n++) begin
            @(negedge clk);
            if (n == nd) drive(sel, 1'b0, (off + 3) % (1 << wid));   // ignored outside reset
            check_int("R2", $sformatf("cfg%0d seed %0d cycle %0d first", sel, off, n),
                      dom_of(sel, 0), (base + n) % nd);
            check_stages(sel, nd, mask, (base + n) % nd);
            if (n > 1)
                for (int k = 1; k < NS; k++)
                    if (((mask >> k) & 1) == 0)
                        check_int("R8", $sformatf("cfg%0d stage %0d handoff", sel, k),
                                  dom_of(sel, k), prev[k-1]);
            for (int k = 0; k < NS; k++) prev[k] = dom_of(sel, k);
        end
    endtask

    initial begin
        repeat (2) @(posedge clk);
        for (int o = 0; o < (1 << A_W); o++) run_seq(0, A_D, A_M, o, A_W);
        for (int o = 0; o < (1 << B_W); o++) run_seq(1, B_D, B_M, o, B_W);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        #(200000 * 5);
        fails++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule